// File: doc/BRIEF.md
# Write-Completion Status Responder

This block sits in the read path of a byte-alterable nonvolatile memory. It shapes the data a host sees while the array is busy with an internal programming cycle. It records the address and data of the most recent accepted write. While the programming cycle runs, a read of that location returns a status word instead of array contents:

- The top bit is the inverse of the written top bit.
- The next bit alternates on every completed read.
- The remaining low bits repeat the written data.

Reads of any other location, and all reads once programming has finished, return the true array data. The block also produces the output-enable for the shared data bus. A read is active only while both active-low select strobes are low.

A write that the protection logic rejects leaves the recorded location untouched, so it can never make polling report a programming cycle. The alternating bit restarts from a parameter-defined value on every accepted write. It changes only when a status read ends, never during a read that is held for many cycles. Read data and the bus enable are registered and appear one clock after the strobes are sampled.

Top module: `wcs_responder`

## Requirements
- R1: `dq_oe` is low in the cycle after any clock edge that samples `ce_n` or `oe_n` high, and it is low after reset.
- R2: `dq_oe` is high in the cycle after any clock edge that samples both `ce_n` and `oe_n` low, and the read word is presented with that same one-cycle latency.
- R3: When `busy` is low, a read returns `arr_rdata` unchanged.
- R4: During a status read, bit 7 of `dq_out` is the complement of bit 7 of the last accepted write data. A status read is one made while `busy` is high, a write has been accepted since `busy` last fell, and `rd_addr` equals the last accepted write address.
- R5: During status reads, bit 6 of `dq_out` inverts once for each status read that ends. A status read ends when the strobes deassert or the read stops being a status read. Bit 6 stays constant while a single read is held for several cycles.
- R6: Every accepted write sets bit 6 of the next status read to the parameter `TGL_INIT` (default 1).
- R7: During a status read, bits 5 down to 0 of `dq_out` equal bits 5 down to 0 of the last accepted write data.
- R8: While `busy` is high, a read of any address other than the last accepted write address returns `arr_rdata`.
- R9: After `busy` falls, a read of the previously polled address returns `arr_rdata`.
- R10: A write strobe with `wr_block` high changes neither the recorded address nor the recorded data. Reading its address while busy returns array data, and the earlier location still answers with status.
- R11: An accepted write while `busy` is high (a further page load) replaces the recorded location. Status then follows the new byte, and the old address returns array data.
- R12: If `busy` rises with no write accepted since it last fell, reads return array data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busy | input | 1 | Internal programming cycle in progress |
| wr_en | input | 1 | One-cycle strobe marking a completed byte write |
| wr_block | input | 1 | With `wr_en`: the write was rejected by protection |
| wr_addr | input | ADDR_W | Address of the write |
| wr_data | input | DATA_W | Data of the write |
| ce_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output enable |
| rd_addr | input | ADDR_W | Read address |
| arr_rdata | input | DATA_W | True data from the array at `rd_addr` |
| dq_out | output | DATA_W | Read word toward the bus |
| dq_oe | output | 1 | Drive enable for the data bus |

## Verification
A wrong recorded address or a stale armed flag shows on the very next read as the wrong kind of word. Array data appears where status was due, or the reverse, and the top bit is the clearest sign. A toggle register that is off by one read, or that is not reloaded on a write, shows as bit 6 disagreeing with the expected parity on the first status read after the fault. A held read exposes a toggle that flips on clocks instead of on read ends within two cycles. Bus-enable faults show one cycle after a strobe change.

// File: rtl/wcs_pkg.sv
package wcs_pkg;

    // Classification of the read sampled in a given cycle
    typedef enum logic [1:0] {
        RK_IDLE   = 2'd0,
        RK_ARRAY  = 2'd1,
        RK_STATUS = 2'd2
    } rd_kind_e;

endpackage

// File: rtl/wcs_last_write.sv
module wcs_last_write #(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic              wr_en,
    input  logic              wr_block,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [ADDR_W-1:0] last_addr,
    output logic [DATA_W-1:0] last_data,
    output logic              armed,
    output logic              wr_take
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              armed;
        logic              busy;
    } lw_state_t;

    lw_state_t st_d, st_q;

    assign wr_take = wr_en && !wr_block;

    always_comb begin
        st_d      = st_q;
        st_d.busy = busy;
        // end of a programming cycle disarms polling
        if (st_q.busy && !busy) begin
            st_d.armed = 1'b0;
        end
        // an accepted write records the location and arms polling
        if (wr_take) begin
            st_d.addr  = wr_addr;
            st_d.data  = wr_data;
            st_d.armed = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign last_addr = st_q.addr;
    assign last_data = st_q.data;
    assign armed     = st_q.armed;

    // R10: a rejected write leaves the recorded location alone
    p_reject_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_block) |=> ($stable(last_addr) && $stable(last_data)));

    // R12: a falling busy with no accepted write leaves polling disarmed
    p_disarm_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !busy && !wr_en) |=> !armed);

    // R11: an accepted write is recorded
    p_record_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_block) |=> (armed && last_addr == $past(wr_addr)
                                   && last_data == $past(wr_data)));

endmodule

// File: rtl/wcs_toggle.sv
module wcs_toggle
    import wcs_pkg::*;
#(
    parameter logic TGL_INIT = 1'b1
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     reload,
    input  rd_kind_e rd_kind,
    output logic     tgl
);

    typedef struct packed {
        logic tgl;
        logic was_status;
    } tg_state_t;

    tg_state_t st_d, st_q;
    logic      status_now;
    logic      status_end;

    assign status_now = (rd_kind == RK_STATUS);
    assign status_end = st_q.was_status && !status_now;

    always_comb begin
        st_d            = st_q;
        st_d.was_status = status_now;
        if (status_end) begin
            st_d.tgl = ~st_q.tgl;
        end
        if (reload) begin
            st_d.tgl = TGL_INIT;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{tgl: TGL_INIT, was_status: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign tgl = st_q.tgl;

    // R5: a held status read never changes the toggle
    p_hold_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.was_status && status_now && !reload) |=> $stable(tgl));

    // R5: toggle changes only at the end of a status read or on reload
    p_only_at_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!status_end && !reload) |=> $stable(tgl));

    // R6: reload puts the toggle at its defined starting value
    p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (tgl == TGL_INIT));

endmodule

// File: rtl/wcs_read_path.sv
module wcs_read_path
    import wcs_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  rd_kind_e          rd_kind,
    input  logic [DATA_W-1:0] arr_rdata,
    input  logic [DATA_W-1:0] last_data,
    input  logic              tgl,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);

    localparam int POLL_POS = DATA_W - 1;
    localparam int TGL_POS  = DATA_W - 2;

    typedef struct packed {
        logic [DATA_W-1:0] dq;
        logic              oe;
    } rp_state_t;

    rp_state_t         st_d, st_q;
    logic [DATA_W-1:0] stat_word;

    // status word: inverted top bit, toggle below it, written data elsewhere
    for (genvar b = 0; b < DATA_W; b++) begin : g_stat_bit
        if (b == POLL_POS) begin : g_poll
            assign stat_word[b] = ~last_data[b];
        end else if (b == TGL_POS) begin : g_tgl
            assign stat_word[b] = tgl;
        end else begin : g_echo
            assign stat_word[b] = last_data[b];
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (rd_kind)
            RK_STATUS: begin
                st_d.dq = stat_word;
                st_d.oe = 1'b1;
            end
            RK_ARRAY: begin
                st_d.dq = arr_rdata;
                st_d.oe = 1'b1;
            end
            default: begin
                st_d.dq = '0;
                st_d.oe = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dq_out = st_q.dq;
    assign dq_oe  = st_q.oe;

    // R3, R8, R9: an array read passes the array word through
    p_array_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_kind == RK_ARRAY) |=> (dq_out == $past(arr_rdata)));

    // R4: status read inverts the polled bit of the written data
    p_poll_inv_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_kind == RK_STATUS) |=> (dq_out[POLL_POS] != $past(last_data[POLL_POS])));

    // R7: low bits of a status read echo the written data
    p_low_echo_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_kind == RK_STATUS) |=>
            (dq_out[TGL_POS-1:0] == $past(last_data[TGL_POS-1:0])));

endmodule

// File: rtl/wcs_responder.sv
module wcs_responder
    import wcs_pkg::*;
#(
    parameter int   ADDR_W   = 19,
    parameter int   DATA_W   = 8,
    parameter logic TGL_INIT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic              wr_en,
    input  logic              wr_block,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] arr_rdata,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);

    logic [ADDR_W-1:0] last_addr;
    logic [DATA_W-1:0] last_data;
    logic              armed;
    logic              wr_take;
    logic              tgl;
    logic              rd_act;
    logic              hit;
    rd_kind_e          rd_kind;

    wcs_last_write #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_last (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy      (busy),
        .wr_en     (wr_en),
        .wr_block  (wr_block),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .last_addr (last_addr),
        .last_data (last_data),
        .armed     (armed),
        .wr_take   (wr_take)
    );

    // read classification
    assign rd_act = !ce_n && !oe_n;
    assign hit    = busy && armed && (rd_addr == last_addr);

    always_comb begin
        if (!rd_act) begin
            rd_kind = RK_IDLE;
        end else if (hit) begin
            rd_kind = RK_STATUS;
        end else begin
            rd_kind = RK_ARRAY;
        end
    end

    wcs_toggle #(.TGL_INIT(TGL_INIT)) i_tgl (
        .clk     (clk),
        .rst_n   (rst_n),
        .reload  (wr_take),
        .rd_kind (rd_kind),
        .tgl     (tgl)
    );

    wcs_read_path #(.DATA_W(DATA_W)) i_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_kind   (rd_kind),
        .arr_rdata (arr_rdata),
        .last_data (last_data),
        .tgl       (tgl),
        .dq_out    (dq_out),
        .dq_oe     (dq_oe)
    );

    // R1: either strobe high releases the bus on the next cycle
    p_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n || oe_n) |=> !dq_oe);

    // R2: both strobes low drive the bus on the next cycle
    p_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n) |=> dq_oe);

    // R9: with no programming cycle the bus carries array data
    p_idle_true_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_act && !busy) |=> (dq_out == $past(arr_rdata)));

endmodule

// File: tb/test_wcs_responder.sv
module test_wcs_responder;

    localparam int AW = 19;
    localparam int DW = 8;

    typedef struct {
        logic [DW-1:0] val;
        string         req;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          busy = 1'b0;
    logic          wr_en = 1'b0;
    logic          wr_block = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          ce_n = 1'b1;
    logic          oe_n = 1'b1;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] arr_rdata;
    logic [DW-1:0] dq_out;
    logic          dq_oe;

    int   n_chk = 0;
    int   n_bad = 0;
    exp_t exp_q[$];

    // bench-side reference state
    logic [AW-1:0] m_addr  = '0;
    logic [DW-1:0] m_data  = '0;
    logic          m_armed = 1'b0;
    logic          m_tgl   = 1'b1;

    always #5 clk = ~clk;

    function automatic logic [DW-1:0] arr_of(input logic [AW-1:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    assign arr_rdata = arr_of(rd_addr);

    wcs_responder #(.ADDR_W(AW), .DATA_W(DW), .TGL_INIT(1'b1)) i_wcs_responder (
        .clk(clk), .rst_n(rst_n), .busy(busy), .wr_en(wr_en), .wr_block(wr_block),
        .wr_addr(wr_addr), .wr_data(wr_data), .ce_n(ce_n), .oe_n(oe_n),
        .rd_addr(rd_addr), .arr_rdata(arr_rdata), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    task automatic check(input string req, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: compare each newly driven read word with the queue head
    logic mon_prev_oe = 1'b0;
    always @(negedge clk) begin
        if (dq_oe === 1'b1 && mon_prev_oe !== 1'b1) begin
            if (exp_q.size() == 0) begin
                n_chk++;
                n_bad++;
                $display("FAIL R2 actual=%h expected=none (unexpected read)", dq_out);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(e.req, dq_out, e.val);
            end
        end
        mon_prev_oe = dq_oe;
    end

    // expected word for a read, from the requirements
    function automatic logic [DW-1:0] expect_of(input logic [AW-1:0] a,
                                                output logic is_stat);
        is_stat = busy && m_armed && (a == m_addr);
        if (is_stat) begin
            return {~m_data[7], m_tgl, m_data[5:0]};
        end
        return arr_of(a);
    endfunction

    task automatic do_read(input logic [AW-1:0] a, input int hold, input string req);
        exp_t        e;
        logic        st;
        logic [DW-1:0] v;
        @(negedge clk);
        v = expect_of(a, st);
        e.val = v;
        e.req = req;
        exp_q.push_back(e);
        rd_addr = a;
        ce_n = 1'b0;
        oe_n = 1'b0;
        @(negedge clk);
        for (int k = 1; k < hold; k++) begin
            @(negedge clk);
            check("R5 held read stable", dq_out, v);
        end
        ce_n = 1'b1;
        oe_n = 1'b1;
        if (st) m_tgl = ~m_tgl;
        @(negedge clk);
        check("R1 released", {7'd0, dq_oe}, 8'd0);
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                            input logic blk);
        @(negedge clk);
        wr_en = 1'b1;
        wr_block = blk;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        wr_block = 1'b0;
        if (!blk) begin
            m_addr = a;
            m_data = d;
            m_armed = 1'b1;
            m_tgl = 1'b1;
        end
    endtask

    task automatic set_busy(input logic b);
        @(negedge clk);
        busy = b;
        if (!b) m_armed = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset oe", {7'd0, dq_oe}, 8'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle oe", {7'd0, dq_oe}, 8'd0);

        // R3: idle read returns array data
        do_read(19'h00123, 1, "R3 idle array");

        // R4, R6, R7: write then poll
        do_write(19'h05555, 8'h3C, 1'b0);
        set_busy(1'b1);
        do_read(19'h05555, 1, "R4 R6 R7 first status");
        do_read(19'h05555, 4, "R5 second status, held");
        do_read(19'h00777, 1, "R8 other address");
        do_read(19'h05555, 1, "R5 third status");

        // R10: rejected write changes nothing
        do_write(19'h02AAA, 8'h55, 1'b1);
        do_read(19'h02AAA, 1, "R10 rejected address");
        do_read(19'h05555, 2, "R10 old location status");

        // R11: further page load moves the polled location
        do_write(19'h05556, 8'hC3, 1'b0);
        do_read(19'h05556, 1, "R11 R6 new byte status");
        do_read(19'h05555, 1, "R11 old byte array");
        do_read(19'h05556, 1, "R5 R11 toggled");

        // R9: end of programming
        set_busy(1'b0);
        do_read(19'h05556, 1, "R9 true data");
        do_read(19'h05556, 1, "R9 no toggle");

        // R12: busy with nothing armed
        set_busy(1'b1);
        do_read(19'h05556, 1, "R12 unarmed busy");
        set_busy(1'b0);

        // R1: one strobe low is not a read
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b1;
        @(negedge clk);
        check("R1 ce only", {7'd0, dq_oe}, 8'd0);
        ce_n = 1'b1; oe_n = 1'b0;
        @(negedge clk);
        check("R1 oe only", {7'd0, dq_oe}, 8'd0);
        oe_n = 1'b1;
        @(negedge clk);

        if (exp_q.size() != 0) begin
            n_chk++;
            n_bad++;
            $display("FAIL R2 actual=%0d expected=0 pending reads", exp_q.size());
        end
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule